// File: doc/BRIEF.md
# DLL Re-enable Command Sequencer

This block sits on the controller side of a DDR3-style memory channel. It brings a device that has been running with its delay-locked loop switched off back into normal operation at a new clock frequency. A start request, accepted only while the block is idle, launches a fixed recovery order. The block puts the device into self-refresh and gives the clock time to settle. It then waits for the host to report a stable new clock, takes the device out of self-refresh, and writes three mode registers: one switches the DLL on, one resets the DLL, and one loads the new latency and recovery settings.

Every gap between steps comes from a wait-length input counted in clock cycles, so one design serves any speed grade and frequency. A single down-counter, reloaded at each step, times all the gaps. The block drives NOP on every cycle that carries no command. It keeps ODT low for the whole run, because termination may not be used while the DLL is off. It pulses `done` once the device may take normal commands and its DLL has had time to lock.

Top module: `dll_relock_seq`

## Requirements
- R1: After a synchronous reset the command bus shows NOP, `cke` is high, `odt` is low and `done` is low. A `start` sampled high in idle makes the next cycle carry self-refresh entry.
- R2: Commands come out in the order self-refresh entry, self-refresh exit, MRS to register 1, MRS to register 0, update MRS, then `done`. Command codes are NOP=0, SRE=1, SRX=2, MRS=3. Every other cycle carries NOP, and `mrSel`/`mrData` are zero except on MRS cycles. The update MRS drives `updSel` and `updValue` unchanged.
- R3: The first MRS selects register 1 (`mrSel`=1) and carries `mr1Value` with bit 0 forced to 0, which turns the DLL on.
- R4: The second MRS selects register 0 (`mrSel`=0) and carries `mr0Value` with bit 8 forced to 1, which starts a DLL reset.
- R5: With g(N) = max(N, 2), the spacing from self-refresh entry to the frequency-change state is g(`waitCkSre`). The spacing from exit to the first MRS is g(`waitXs`), and the spacing between successive MRS commands is g(`waitMrd`).
- R6: In the frequency-change state, the first cycle with `freqStable` high starts the exit wait. Self-refresh exit follows that cycle by g(max(`waitCkSrx`, `waitCkEsr`)).
- R7: `done` is high for exactly one cycle. It comes g(max(`waitMod`, `waitDllk` − g(`waitMrd`))) cycles after the update MRS, where the difference saturates at 0.
- R8: `cke` is low from the entry cycle up to the cycle before exit, and high on every other cycle. `odt` is low on every cycle.
- R9: `start` has no effect while a sequence runs, and `freqStable` has no effect outside the frequency-change state.
- R10: A synchronous reset in the middle of a sequence returns the block to idle (R1 state), and a later start runs a complete fresh sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a recovery sequence (idle only) |
| freqStable | input | 1 | Host reports the new clock as stable |
| waitCkSre | input | WAIT_W | Entry-to-clock-change gap, cycles |
| waitCkEsr | input | WAIT_W | Minimum self-refresh residency, cycles |
| waitCkSrx | input | WAIT_W | Stable clock before exit, cycles |
| waitXs | input | WAIT_W | Exit to first MRS, cycles |
| waitMrd | input | WAIT_W | MRS to MRS, cycles |
| waitMod | input | WAIT_W | Last MRS to normal command, cycles |
| waitDllk | input | WAIT_W | DLL lock time from DLL reset, cycles |
| mr1Value | input | MR_W | Register 1 contents for the DLL-on write |
| mr0Value | input | MR_W | Register 0 contents for the DLL-reset write |
| updSel | input | SEL_W | Register chosen by the update MRS |
| updValue | input | MR_W | Data for the update MRS |
| cmd | output | 2 | Command code (NOP/SRE/SRX/MRS) |
| mrSel | output | SEL_W | Mode register select on MRS cycles |
| mrData | output | MR_W | Mode register data on MRS cycles |
| cke | output | 1 | Clock enable to the device |
| odt | output | 1 | On-die termination, held low |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is the frequency-change state itself. It only matters when `freqStable` arrives late, and it is easy to hide a defect where the flag is taken before that state is reached. The stimulus therefore drops the flag, pulses it once during the entry wait, and raises it for good several cycles after the state begins. The expected exit cycle then depends only on the late rise. A second `start` pulse lands inside the same wait, so a restart would show up as an extra entry command in the scoreboard. The DLL lock term is made to dominate the final wait in one run and `waitMod` in another, so both arms of the last maximum are compared against computed cycles.

// File: rtl/dll_relock_pkg.sv
package dll_relock_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_SRE = 2'd1,
    CMD_SRX = 2'd2,
    CMD_MRS = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    WS_CKSRE,
    WS_SREXIT,
    WS_XS,
    WS_MRD,
    WS_FINAL
  } wait_sel_e;

  typedef enum logic [1:0] {
    MS_NONE,
    MS_DLLON,
    MS_DLLRST,
    MS_UPDATE
  } mrs_kind_e;

  typedef struct packed {
    logic      load;
    wait_sel_e waitSel;
    cmd_e      cmd;
    mrs_kind_e mrsKind;
  } ctrl_strobe_t;

endpackage

// File: rtl/dll_relock_ctrl.sv
module dll_relock_ctrl
  import dll_relock_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         freqStable,
  input  logic         cntLast,
  output ctrl_strobe_t strobe,
  output logic         cke,
  output logic         done
);

  typedef enum logic [3:0] {
    ST_IDLE, ST_SRE, ST_W_SRE, ST_FREQ, ST_W_SRX, ST_SRX, ST_W_XS,
    ST_MR1, ST_W_M1, ST_MR0, ST_W_M0, ST_UPD, ST_W_FIN, ST_DONE
  } state_e;

  state_e state, stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    stateNext      = state;
    strobe.load    = 1'b0;
    strobe.waitSel = WS_CKSRE;
    strobe.cmd     = CMD_NOP;
    strobe.mrsKind = MS_NONE;
    done           = 1'b0;
    unique case (state)
      ST_IDLE:  if (start) stateNext = ST_SRE;
      ST_SRE: begin
        strobe.cmd     = CMD_SRE;
        strobe.load    = 1'b1;
        strobe.waitSel = WS_CKSRE;
        stateNext      = ST_W_SRE;
      end
      ST_W_SRE: if (cntLast) stateNext = ST_FREQ;
      ST_FREQ: begin
        if (freqStable) begin
          strobe.load    = 1'b1;
          strobe.waitSel = WS_SREXIT;
          stateNext      = ST_W_SRX;
        end
      end
      ST_W_SRX: if (cntLast) stateNext = ST_SRX;
      ST_SRX: begin
        strobe.cmd     = CMD_SRX;
        strobe.load    = 1'b1;
        strobe.waitSel = WS_XS;
        stateNext      = ST_W_XS;
      end
      ST_W_XS:  if (cntLast) stateNext = ST_MR1;
      ST_MR1: begin
        strobe.cmd     = CMD_MRS;
        strobe.mrsKind = MS_DLLON;
        strobe.load    = 1'b1;
        strobe.waitSel = WS_MRD;
        stateNext      = ST_W_M1;
      end
      ST_W_M1:  if (cntLast) stateNext = ST_MR0;
      ST_MR0: begin
        strobe.cmd     = CMD_MRS;
        strobe.mrsKind = MS_DLLRST;
        strobe.load    = 1'b1;
        strobe.waitSel = WS_MRD;
        stateNext      = ST_W_M0;
      end
      ST_W_M0:  if (cntLast) stateNext = ST_UPD;
      ST_UPD: begin
        strobe.cmd     = CMD_MRS;
        strobe.mrsKind = MS_UPDATE;
        strobe.load    = 1'b1;
        strobe.waitSel = WS_FINAL;
        stateNext      = ST_W_FIN;
      end
      ST_W_FIN: if (cntLast) stateNext = ST_DONE;
      ST_DONE: begin
        done      = 1'b1;
        stateNext = ST_IDLE;
      end
      default:  stateNext = ST_IDLE;
    endcase
  end

  // Device clock enable is dropped for the whole self-refresh residency.
  assign cke = !(state inside {ST_SRE, ST_W_SRE, ST_FREQ, ST_W_SRX});

endmodule

// File: rtl/dll_relock_dp.sv
module dll_relock_dp
  import dll_relock_pkg::*;
#(
  parameter int WAIT_W      = 16,
  parameter int MR_W        = 14,
  parameter int SEL_W       = 3,
  parameter int DLL_OFF_BIT = 0,
  parameter int DLL_RST_BIT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_strobe_t      strobe,
  input  logic [WAIT_W-1:0] waitCkSre,
  input  logic [WAIT_W-1:0] waitCkEsr,
  input  logic [WAIT_W-1:0] waitCkSrx,
  input  logic [WAIT_W-1:0] waitXs,
  input  logic [WAIT_W-1:0] waitMrd,
  input  logic [WAIT_W-1:0] waitMod,
  input  logic [WAIT_W-1:0] waitDllk,
  input  logic [MR_W-1:0]   mr1Value,
  input  logic [MR_W-1:0]   mr0Value,
  input  logic [SEL_W-1:0]  updSel,
  input  logic [MR_W-1:0]   updValue,
  output logic              cntLast,
  output logic [1:0]        cmdOut,
  output logic [SEL_W-1:0]  mrSel,
  output logic [MR_W-1:0]   mrData
);

  localparam logic [WAIT_W-1:0] MIN_GAP = WAIT_W'(2);
  localparam logic [MR_W-1:0]   OFF_MASK = MR_W'(1) << DLL_OFF_BIT;
  localparam logic [MR_W-1:0]   RST_MASK = MR_W'(1) << DLL_RST_BIT;

  logic [WAIT_W-1:0] cnt;
  logic [WAIT_W-1:0] loadVal;
  logic [WAIT_W-1:0] exitWait;
  logic [WAIT_W-1:0] mrdGap;
  logic [WAIT_W-1:0] dllkRem;
  logic [WAIT_W-1:0] finalWait;

  // Exit wait covers both the stable-clock time and the residency floor.
  assign exitWait  = (waitCkSrx > waitCkEsr) ? waitCkSrx : waitCkEsr;
  // Lock time still owed once the last MRS has gone out.
  assign mrdGap    = (waitMrd < MIN_GAP) ? MIN_GAP : waitMrd;
  assign dllkRem   = (waitDllk > mrdGap) ? (waitDllk - mrdGap) : '0;
  assign finalWait = (waitMod > dllkRem) ? waitMod : dllkRem;

  always_comb begin
    unique case (strobe.waitSel)
      WS_CKSRE:  loadVal = waitCkSre;
      WS_SREXIT: loadVal = exitWait;
      WS_XS:     loadVal = waitXs;
      WS_MRD:    loadVal = waitMrd;
      WS_FINAL:  loadVal = finalWait;
      default:   loadVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                 cnt <= '0;
    else if (strobe.load)    cnt <= (loadVal == '0) ? '0 : loadVal - WAIT_W'(1);
    else if (cnt != '0)      cnt <= cnt - WAIT_W'(1);
  end

  assign cntLast = (cnt <= WAIT_W'(1));

  always_comb begin
    cmdOut = strobe.cmd;
    mrSel  = '0;
    mrData = '0;
    unique case (strobe.mrsKind)
      MS_DLLON: begin
        mrSel  = SEL_W'(1);
        mrData = mr1Value & ~OFF_MASK;
      end
      MS_DLLRST: begin
        mrSel  = SEL_W'(0);
        mrData = mr0Value | RST_MASK;
      end
      MS_UPDATE: begin
        mrSel  = updSel;
        mrData = updValue;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/dll_relock_seq.sv
module dll_relock_seq
  import dll_relock_pkg::*;
#(
  parameter int WAIT_W      = 16,
  parameter int MR_W        = 14,
  parameter int SEL_W       = 3,
  parameter int DLL_OFF_BIT = 0,
  parameter int DLL_RST_BIT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              freqStable,
  input  logic [WAIT_W-1:0] waitCkSre,
  input  logic [WAIT_W-1:0] waitCkEsr,
  input  logic [WAIT_W-1:0] waitCkSrx,
  input  logic [WAIT_W-1:0] waitXs,
  input  logic [WAIT_W-1:0] waitMrd,
  input  logic [WAIT_W-1:0] waitMod,
  input  logic [WAIT_W-1:0] waitDllk,
  input  logic [MR_W-1:0]   mr1Value,
  input  logic [MR_W-1:0]   mr0Value,
  input  logic [SEL_W-1:0]  updSel,
  input  logic [MR_W-1:0]   updValue,
  output logic [1:0]        cmd,
  output logic [SEL_W-1:0]  mrSel,
  output logic [MR_W-1:0]   mrData,
  output logic              cke,
  output logic              odt,
  output logic              done
);

  ctrl_strobe_t strobe;
  logic         cntLast;

  dll_relock_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .freqStable(freqStable),
    .cntLast(cntLast), .strobe(strobe), .cke(cke), .done(done)
  );

  dll_relock_dp #(
    .WAIT_W(WAIT_W), .MR_W(MR_W), .SEL_W(SEL_W),
    .DLL_OFF_BIT(DLL_OFF_BIT), .DLL_RST_BIT(DLL_RST_BIT)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .waitCkSre(waitCkSre), .waitCkEsr(waitCkEsr), .waitCkSrx(waitCkSrx),
    .waitXs(waitXs), .waitMrd(waitMrd), .waitMod(waitMod), .waitDllk(waitDllk),
    .mr1Value(mr1Value), .mr0Value(mr0Value), .updSel(updSel), .updValue(updValue),
    .cntLast(cntLast), .cmdOut(cmd), .mrSel(mrSel), .mrData(mrData)
  );

  // Termination stays off: it is not allowed while the DLL is disabled.
  assign odt = 1'b0;

endmodule

// File: rtl/dll_relock_chk.sv
module dll_relock_chk #(
  parameter int MR_W        = 14,
  parameter int SEL_W       = 3,
  parameter int DLL_OFF_BIT = 0,
  parameter int DLL_RST_BIT = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       cmd,
  input logic [SEL_W-1:0] mrSel,
  input logic [MR_W-1:0]  mrData,
  input logic             cke,
  input logic             done
);

  logic [1:0] mrsCnt;

  always_ff @(posedge clk) begin
    if (rst || cmd == 2'd1)               mrsCnt <= '0;
    else if (cmd == 2'd3 && mrsCnt != 2'd3) mrsCnt <= mrsCnt + 2'd1;
  end

  assert_cke_at_entry_R8: assert property (@(posedge clk) disable iff (rst)
    cmd == 2'd1 |-> !cke);

  assert_cke_at_exit_R8: assert property (@(posedge clk) disable iff (rst)
    cmd == 2'd2 |-> cke && !$past(cke));

  assert_mr1_dll_on_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd == 2'd3 && mrsCnt == 2'd0) |-> (mrSel == SEL_W'(1) && !mrData[DLL_OFF_BIT]));

  assert_mr0_dll_reset_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd == 2'd3 && mrsCnt == 2'd1) |-> (mrSel == SEL_W'(0) && mrData[DLL_RST_BIT]));

  assert_mrs_gap_R5: assert property (@(posedge clk) disable iff (rst)
    cmd == 2'd3 |=> cmd == 2'd0);

  assert_done_after_mrs_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (mrsCnt == 2'd3 && cmd == 2'd0));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_quiet_bus_R2: assert property (@(posedge clk) disable iff (rst)
    cmd != 2'd3 |-> (mrSel == '0 && mrData == '0));

  assert_entry_from_idle_R9: assert property (@(posedge clk) disable iff (rst)
    cmd == 2'd1 |-> ($past(cke) && $past(cmd) == 2'd0));

endmodule

bind dll_relock_seq dll_relock_chk #(
  .MR_W(MR_W), .SEL_W(SEL_W), .DLL_OFF_BIT(DLL_OFF_BIT), .DLL_RST_BIT(DLL_RST_BIT)
) u_chk (
  .clk(clk), .rst(rst), .cmd(cmd), .mrSel(mrSel), .mrData(mrData),
  .cke(cke), .done(done)
);

// File: tb/dll_relock_seq_bench.sv
`timescale 1ns/1ps
module dll_relock_seq_bench;

  localparam int WAIT_W = 16;
  localparam int MR_W   = 14;
  localparam int SEL_W  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic freqStable = 1'b0;
  logic [WAIT_W-1:0] waitCkSre = '0, waitCkEsr = '0, waitCkSrx = '0, waitXs = '0;
  logic [WAIT_W-1:0] waitMrd = '0, waitMod = '0, waitDllk = '0;
  logic [MR_W-1:0]   mr1Value = '0, mr0Value = '0, updValue = '0;
  logic [SEL_W-1:0]  updSel = '0;
  logic [1:0]        cmd;
  logic [SEL_W-1:0]  mrSel;
  logic [MR_W-1:0]   mrData;
  logic              cke, odt, done;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int qCyc[$], qKind[$], qSel[$], qData[$];
  string qTag[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dll_relock_seq u_dll_relock_seq (
    .clk(clk), .rst(rst), .start(start), .freqStable(freqStable),
    .waitCkSre(waitCkSre), .waitCkEsr(waitCkEsr), .waitCkSrx(waitCkSrx),
    .waitXs(waitXs), .waitMrd(waitMrd), .waitMod(waitMod), .waitDllk(waitDllk),
    .mr1Value(mr1Value), .mr0Value(mr0Value), .updSel(updSel), .updValue(updValue),
    .cmd(cmd), .mrSel(mrSel), .mrData(mrData), .cke(cke), .odt(odt), .done(done)
  );

  function automatic int g(int n);
    return (n < 2) ? 2 : n;
  endfunction

  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic push(int c, int kind, int sel, int data, string tag);
    qCyc.push_back(c); qKind.push_back(kind); qSel.push_back(sel);
    qData.push_back(data); qTag.push_back(tag);
  endtask

  task automatic flushQ();
    qCyc.delete(); qKind.delete(); qSel.delete(); qData.delete(); qTag.delete();
  endtask

  task automatic waitCyc(int c);
    while (cyc < c) @(negedge clk);
  endtask

  // Monitor: every non-NOP command or done pulse is popped and compared.
  always @(negedge clk) begin
    if (!rst && (cmd != 2'd0 || done)) begin
      int kind;
      kind = done ? 4 : int'(cmd);
      if (qCyc.size() == 0) begin
        check(1'b0, "R2/R9 unexpected event kind", kind, 0);
      end else begin
        int eC, eK, eS, eD;
        string t;
        eC = qCyc.pop_front(); eK = qKind.pop_front(); eS = qSel.pop_front();
        eD = qData.pop_front(); t = qTag.pop_front();
        check(cyc == eC, {t, " cycle"}, cyc, eC);
        check(kind == eK, {t, " kind"}, kind, eK);
        check(int'(mrSel) == eS && int'(mrData) == eD, {t, " sel*65536+data"},
              int'(mrSel) * 65536 + int'(mrData), eS * 65536 + eD);
        check(cke == (eK != 1) && odt == 1'b0, {t, " R8 cke*2+odt"},
              int'(cke) * 2 + int'(odt), (eK != 1) ? 2 : 0);
      end
    end
  end

  task automatic runSeq(int sre, int esr, int srx, int xs, int mrd, int mod, int dllk,
                        int freqLag, bit pokeStart, bit pokeFreq,
                        int m1, int m0, int us, int uv);
    int s, tSre, fe, f, tSrx, tM1, tM0, tU, dl, tD;
    @(negedge clk);
    waitCkSre = WAIT_W'(sre); waitCkEsr = WAIT_W'(esr); waitCkSrx = WAIT_W'(srx);
    waitXs = WAIT_W'(xs); waitMrd = WAIT_W'(mrd); waitMod = WAIT_W'(mod);
    waitDllk = WAIT_W'(dllk);
    mr1Value = MR_W'(m1); mr0Value = MR_W'(m0); updSel = SEL_W'(us); updValue = MR_W'(uv);
    freqStable = (freqLag == 0);
    start = 1'b1;
    s = cyc;
    tSre = s + 1;
    push(tSre, 1, 0, 0, "R1 entry");
    @(negedge clk);
    start = 1'b0;
    fe = tSre + g(sre);
    if (pokeStart || pokeFreq) begin
      waitCyc(tSre + 1);
      if (pokeStart) start = 1'b1;
      if (pokeFreq) freqStable = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (pokeFreq) freqStable = 1'b0;
      check(cke == 1'b0, "R8 cke low in self-refresh", int'(cke), 0);
    end
    if (freqLag == 0) f = fe;
    else begin
      f = fe + freqLag;
      waitCyc(f);
      check(cke == 1'b0 && cmd == 2'd0, "R6/R9 still waiting for clock", int'(cke) + int'(cmd), 0);
      freqStable = 1'b1;
    end
    tSrx = f + g(mx(srx, esr));
    push(tSrx, 2, 0, 0, "R6 exit");
    tM1 = tSrx + g(xs);
    push(tM1, 3, 1, m1 & ~1, "R3 dll on");
    tM0 = tM1 + g(mrd);
    push(tM0, 3, 0, m0 | 256, "R4 dll reset");
    tU = tM0 + g(mrd);
    push(tU, 3, us, uv, "R2 update");
    dl = dllk - g(mrd);
    if (dl < 0) dl = 0;
    tD = tU + g(mx(mod, dl));
    push(tD, 4, 0, 0, "R7 done");
    while (qCyc.size() != 0) @(negedge clk);
    @(negedge clk);
    check(done == 1'b0 && cke == 1'b1 && cmd == 2'd0 && odt == 1'b0, "R7/R8 back to idle",
          int'(done) + int'(!cke) + int'(cmd) + int'(odt), 0);
    freqStable = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(cmd == 2'd0, "R1 reset cmd", int'(cmd), 0);
    check(cke == 1'b1 && odt == 1'b0 && done == 1'b0, "R1 reset cke/odt/done",
          int'(cke) * 4 + int'(odt) * 2 + int'(done), 4);

    // R5 R6 R7: moderate waits, lock time dominates the final wait
    runSeq(5, 4, 10, 12, 4, 12, 30, 0, 1'b0, 1'b0, 14'h0A5B, 14'h0031, 0, 14'h0071);
    // R5 R6 R9: minimum spacing, residency floor dominates, late clock, stray start/flag
    runSeq(3, 20, 6, 1, 0, 0, 0, 7, 1'b1, 1'b1, 14'h3FFF, 14'h0000, 2, 14'h0018);
    // R7: long lock time with zero waits elsewhere
    runSeq(0, 0, 0, 2, 2, 2, 100, 0, 1'b0, 1'b0, 14'h0001, 14'h1234, 0, 14'h2AAA);

    // R10: reset in the middle of self-refresh
    @(negedge clk);
    waitCkSre = 16'd4; waitCkEsr = 16'd4; waitCkSrx = 16'd4; freqStable = 1'b0;
    start = 1'b1;
    push(cyc + 1, 1, 0, 0, "R10 entry before reset");
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    check(cke == 1'b0, "R10 in self-refresh before reset", int'(cke), 0);
    rst = 1'b1;
    flushQ();
    repeat (2) @(negedge clk);
    rst = 1'b0;
    freqStable = 1'b1;
    @(negedge clk);
    check(cke == 1'b1 && cmd == 2'd0 && done == 1'b0, "R10 idle after reset",
          int'(!cke) + int'(cmd) + int'(done), 0);
    repeat (20) @(negedge clk);
    check(cke == 1'b1 && qCyc.size() == 0, "R10 stays idle", int'(!cke), 0);
    freqStable = 1'b0;
    runSeq(2, 3, 4, 5, 6, 20, 10, 0, 1'b0, 1'b0, 14'h0155, 14'h02AA, 3, 14'h0008);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired, pending events actual=%0d expected=0", qCyc.size());
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule